// File: doc/BRIEF.md
# Sleep and Wake Event Controller

This block decides when a processor core sleeps and when it wakes. The core raises a one-cycle strobe when it runs a wait-for-interrupt or wait-for-event instruction. It also reports when an interrupt handler returns. The block combines these strobes with the pending and enable state of every interrupt line and with three configuration bits. From that it drives a sleeping flag and a deep-sleep flag for the power logic.

The block holds a single event latch. A software event strobe sets it. If the corresponding configuration bit is on, any interrupt line that newly becomes pending also sets it, whether or not that line is enabled. A wait-for-event either consumes an event that is already held, or sleeps until one arrives. A sleep-on-exit bit sends the core back to sleep when the outermost handler returns, instead of letting it resume the main thread. Software clears the latch explicitly. If a handler does not clear it, a stale event makes the next wait-for-event return at once.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After reset, `sleeping`, `deep_sleep`, `wake_irq` and `event_flag` are all 0.
- R2: A `wfi_req` strobe while awake, with no line both pending and enabled, makes `sleeping` 1 from the next clock edge. Sleep then holds while every pending line is disabled, and an event does not end a wait-for-interrupt sleep.
- R3: During any sleep, `sleeping` and `deep_sleep` fall in the same cycle that a line is both pending and enabled. `wake_irq` is 1 in exactly that cycle, which tells the core a handler is to be taken.
- R4: A `wfi_req` strobe while some line is both pending and enabled does not sleep.
- R5: A `wfe_req` strobe while awake, with the latch clear and no enabled pending line, sleeps from the next edge. It wakes in the same cycle that a new event or an enabled pending line appears. A wake caused by an event alone keeps `wake_irq` at 0 and leaves `event_flag` at 0.
- R6: A `wfe_req` strobe while `event_flag` is 1 does not sleep, and `event_flag` is 0 after the next edge.
- R7: With `cfg_sev_on_pend` at 1, a 0-to-1 change of any `irq_pend` bit sets `event_flag` at the next edge, whether the line is enabled or not. A bit that stays high does not set it again. With `cfg_sev_on_pend` at 0, pending changes have no effect on `event_flag`.
- R8: `evt_clr` clears `event_flag` at the next edge. A new event in the same cycle takes priority, so the flag ends up 1. A flag that is left uncleared makes the next `wfe_req` return without sleeping.
- R9: With `cfg_sleep_on_exit` at 1, a `handler_exit` with `exit_to_thread` at 1 and no enabled pending line starts a wait-for-interrupt sleep at the next edge. A nested exit (`exit_to_thread` at 0) does not start a sleep, and neither does any exit while the bit is 0.
- R10: `deep_sleep` is `sleeping` combined with the value of `cfg_deep` captured at sleep entry. Changing `cfg_deep` during a sleep does not alter it.
- R11: `wfi_req`, `wfe_req` and `handler_exit` strobes that arrive while asleep are ignored. In particular, a `wfe_req` during sleep does not consume `event_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the core |
| wfe_req | input | 1 | Wait-for-event strobe from the core |
| sev_in | input | 1 | Event strobe (software or external) |
| irq_pend | input | N_IRQ | Pending status per interrupt line |
| irq_en | input | N_IRQ | Enable per interrupt line |
| handler_exit | input | 1 | Strobe: a handler is returning |
| exit_to_thread | input | 1 | The returning handler goes back to thread level |
| evt_clr | input | 1 | Clears the event latch |
| cfg_sev_on_pend | input | 1 | Newly pending lines raise events |
| cfg_sleep_on_exit | input | 1 | Sleep again on return to thread level |
| cfg_deep | input | 1 | Depth selection for the next sleep entry |
| sleeping | output | 1 | Core is asleep |
| deep_sleep | output | 1 | Core is asleep at the deep level |
| wake_irq | output | 1 | Wake caused by an enabled pending line this cycle |
| event_flag | output | 1 | Event latch state |

## Verification
Sleep entry, the event latch updates and the sleep-on-exit re-entry are all registered, so they appear one clock edge after their strobe. The fall of `sleeping` and `deep_sleep` on wake, and the `wake_irq` pulse, are combinational and appear in the same cycle as the wake condition. The bench changes inputs 1 ns after a rising edge. It checks the same-cycle wake outputs 1 ns later, before the next edge. It checks registered results 1 ns after the following edge, and removes each strobe at that point so that every strobe lasts exactly one cycle.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
package slp_pkg;

  // Why the core is currently asleep (or not)
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_WFI = 2'd1,
    ST_WFE = 2'd2
  } slp_state_e;

endpackage

// File: rtl/slp_pend_edge.sv
`timescale 1ns/1ps
// Per-line detector for lines that have just become pending
module slp_pend_edge #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] pend,
  output logic [N_IRQ-1:0] rise
);

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    logic prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pend[i];
    end

    assign rise[i] = pend[i] & ~prev_q;
  end

endmodule

// File: rtl/slp_evt_latch.sv
`timescale 1ns/1ps
// One-bit event latch. A consume clears it unconditionally; otherwise a new
// event wins over a clear.
module slp_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic consume_i,
  output logic q
);

  logic q_d;

  always_comb begin
    q_d = q;
    if (consume_i)  q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

endmodule

// File: rtl/slp_state_ctl.sv
`timescale 1ns/1ps
// Sleep state machine: entry from strobes, same-cycle wake
module slp_state_ctl
  import slp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wfi_req,
  input  logic wfe_req,
  input  logic exit_req,
  input  logic irq_live,
  input  logic evt_new,
  input  logic evt_held,
  input  logic deep_sel,
  output logic asleep,
  output logic sleeping,
  output logic deep_sleep,
  output logic wake_irq,
  output logic evt_consume
);

  slp_state_e st_q, st_d;
  logic       deep_q, deep_d;
  logic       wake;

  always_comb begin
    wake = ((st_q == ST_WFI) && irq_live) ||
           ((st_q == ST_WFE) && (irq_live || evt_new));
  end

  always_comb begin
    st_d        = st_q;
    deep_d      = deep_q;
    evt_consume = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (wfe_req) begin
          if (evt_held || evt_new) begin
            evt_consume = 1'b1;
          end else if (!irq_live) begin
            st_d   = ST_WFE;
            deep_d = deep_sel;
          end
        end else if (wfi_req || exit_req) begin
          if (!irq_live) begin
            st_d   = ST_WFI;
            deep_d = deep_sel;
          end
        end
      end
      ST_WFI, ST_WFE: begin
        if (wake) begin
          st_d = ST_RUN;
          if ((st_q == ST_WFE) && evt_new) evt_consume = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      deep_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      deep_q <= deep_d;
    end
  end

  assign asleep     = (st_q != ST_RUN);
  assign sleeping   = asleep && !wake;
  assign deep_sleep = sleeping && deep_q;
  assign wake_irq   = asleep && wake && irq_live;

endmodule

// File: rtl/slp_wake_ctrl.sv
`timescale 1ns/1ps
module slp_wake_ctrl #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_req,
  input  logic             wfe_req,
  input  logic             sev_in,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             handler_exit,
  input  logic             exit_to_thread,
  input  logic             evt_clr,
  input  logic             cfg_sev_on_pend,
  input  logic             cfg_sleep_on_exit,
  input  logic             cfg_deep,
  output logic             sleeping,
  output logic             deep_sleep,
  output logic             wake_irq,
  output logic             event_flag
);

  logic [N_IRQ-1:0] pend_rise;
  logic             irq_live;
  logic             evt_new;
  logic             exit_req;
  logic             evt_consume;
  logic             asleep;

  slp_pend_edge #(.N_IRQ(N_IRQ)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (irq_pend),
    .rise (pend_rise)
  );

  assign irq_live = |(irq_pend & irq_en);
  assign evt_new  = sev_in | (cfg_sev_on_pend & (|pend_rise));
  assign exit_req = handler_exit & exit_to_thread & cfg_sleep_on_exit;

  slp_state_ctl u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfi_req    (wfi_req),
    .wfe_req    (wfe_req),
    .exit_req   (exit_req),
    .irq_live   (irq_live),
    .evt_new    (evt_new),
    .evt_held   (event_flag),
    .deep_sel   (cfg_deep),
    .asleep     (asleep),
    .sleeping   (sleeping),
    .deep_sleep (deep_sleep),
    .wake_irq   (wake_irq),
    .evt_consume(evt_consume)
  );

  slp_evt_latch u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_new),
    .clr_i    (evt_clr),
    .consume_i(evt_consume),
    .q        (event_flag)
  );

endmodule

// File: rtl/slp_wake_ctrl_chk.sv
`timescale 1ns/1ps
module slp_wake_ctrl_chk #(
  parameter int N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wfi_req,
  input logic             wfe_req,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_en,
  input logic             handler_exit,
  input logic             exit_to_thread,
  input logic             cfg_sleep_on_exit,
  input logic             sleeping,
  input logic             deep_sleep,
  input logic             event_flag,
  input logic             asleep
);

  // R3: no sleep indication while an enabled line is pending
  a_r3_no_sleep_with_live_irq: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> ((irq_pend & irq_en) == '0));

  // R4: wait-for-interrupt with a live line stays awake
  a_r4_wfi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && wfi_req && !wfe_req && ((irq_pend & irq_en) != '0)) |=> !asleep);

  // R6: held event is consumed by wait-for-event, no sleep
  a_r6_wfe_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && wfe_req && event_flag) |=> (!asleep && !event_flag));

  // R9: return to thread with sleep-on-exit re-enters sleep
  a_r9_exit_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && handler_exit && exit_to_thread && cfg_sleep_on_exit &&
     !wfe_req && !wfi_req && ((irq_pend & irq_en) == '0)) |=> asleep);

  // R10: deep indication only while sleeping
  a_r10_deep_within_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |-> sleeping);

  // R10: depth fixed for the length of one sleep
  a_r10_deep_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && $past(sleeping)) |-> (deep_sleep == $past(deep_sleep)));

endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wfi_req          (wfi_req),
  .wfe_req          (wfe_req),
  .irq_pend         (irq_pend),
  .irq_en           (irq_en),
  .handler_exit     (handler_exit),
  .exit_to_thread   (exit_to_thread),
  .cfg_sleep_on_exit(cfg_sleep_on_exit),
  .sleeping         (sleeping),
  .deep_sleep       (deep_sleep),
  .event_flag       (event_flag),
  .asleep           (asleep)
);

// File: tb/slp_wake_ctrl_test.sv
`timescale 1ns/1ps
module slp_wake_ctrl_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi_req = 0, wfe_req = 0, sev_in = 0;
  logic [N-1:0] irq_pend = '0, irq_en = '0;
  logic handler_exit = 0, exit_to_thread = 0, evt_clr = 0;
  logic cfg_sev_on_pend = 0, cfg_sleep_on_exit = 0, cfg_deep = 0;
  logic sleeping, deep_sleep, wake_irq, event_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  slp_wake_ctrl #(.N_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_in(sev_in), .irq_pend(irq_pend), .irq_en(irq_en),
    .handler_exit(handler_exit), .exit_to_thread(exit_to_thread),
    .evt_clr(evt_clr), .cfg_sev_on_pend(cfg_sev_on_pend),
    .cfg_sleep_on_exit(cfg_sleep_on_exit), .cfg_deep(cfg_deep),
    .sleeping(sleeping), .deep_sleep(deep_sleep), .wake_irq(wake_irq),
    .event_flag(event_flag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    check("R1 sleeping", sleeping, 1'b0);
    check("R1 deep_sleep", deep_sleep, 1'b0);
    check("R1 wake_irq", wake_irq, 1'b0);
    check("R1 event_flag", event_flag, 1'b0);
  endtask

  task automatic t_wfi_sleep_wake();
    wfi_req = 1; step(); wfi_req = 0;
    check("R2 asleep after wfi", sleeping, 1'b1);
    check("R10 shallow", deep_sleep, 1'b0);
    irq_pend[2] = 1; step();
    check("R2 disabled line keeps sleep", sleeping, 1'b1);
    check("R7 pend rise ignored when cfg off", event_flag, 1'b0);
    irq_en[2] = 1; settle();
    check("R3 same-cycle wake", sleeping, 1'b0);
    check("R3 wake_irq pulse", wake_irq, 1'b1);
    step();
    check("R3 stays awake", sleeping, 1'b0);
    check("R3 wake_irq one cycle", wake_irq, 1'b0);
    irq_pend = '0; irq_en = '0; step();
  endtask

  task automatic t_wfi_blocked();
    irq_pend[1] = 1; irq_en[1] = 1;
    wfi_req = 1; step(); wfi_req = 0;
    check("R4 no sleep with live line", sleeping, 1'b0);
    irq_pend = '0; irq_en = '0; step();
  endtask

  task automatic t_deep_and_ignore();
    cfg_deep = 1;
    wfi_req = 1; step(); wfi_req = 0;
    check("R10 deep at entry", deep_sleep, 1'b1);
    cfg_deep = 0; step();
    check("R10 deep held after cfg change", deep_sleep, 1'b1);
    sev_in = 1; step(); sev_in = 0;
    check("R2 event does not end wfi sleep", sleeping, 1'b1);
    check("R7 event latched", event_flag, 1'b1);
    wfe_req = 1; step(); wfe_req = 0;
    check("R11 wfe while asleep ignored", sleeping, 1'b1);
    check("R11 latch not consumed", event_flag, 1'b1);
    irq_pend[0] = 1; irq_en[0] = 1; settle();
    check("R3 deep drops same cycle", deep_sleep, 1'b0);
    step();
    irq_pend = '0; irq_en = '0;
    evt_clr = 1; step(); evt_clr = 0;
    check("R8 clear", event_flag, 1'b0);
  endtask

  task automatic t_wfe_event();
    wfe_req = 1; step(); wfe_req = 0;
    check("R5 wfe sleeps", sleeping, 1'b1);
    sev_in = 1; settle();
    check("R5 event wake same cycle", sleeping, 1'b0);
    check("R5 event wake no irq", wake_irq, 1'b0);
    step(); sev_in = 0;
    check("R5 latch left clear", event_flag, 1'b0);
    check("R5 awake", sleeping, 1'b0);
  endtask

  task automatic t_wfe_irq();
    wfe_req = 1; step(); wfe_req = 0;
    check("R5 wfe sleeps again", sleeping, 1'b1);
    irq_pend[3] = 1; irq_en[3] = 1; settle();
    check("R5 irq wake", sleeping, 1'b0);
    check("R5 irq wake flagged", wake_irq, 1'b1);
    step();
    irq_pend = '0; irq_en = '0; step();
  endtask

  task automatic t_wfe_latched();
    sev_in = 1; step(); sev_in = 0;
    check("R6 event held", event_flag, 1'b1);
    wfe_req = 1; step(); wfe_req = 0;
    check("R6 no sleep", sleeping, 1'b0);
    check("R6 consumed", event_flag, 1'b0);
  endtask

  task automatic t_sev_on_pend();
    cfg_sev_on_pend = 1;
    irq_pend[5] = 1; step();
    check("R7 disabled line rise sets latch", event_flag, 1'b1);
    evt_clr = 1; step(); evt_clr = 0;
    check("R8 clear with level held", event_flag, 1'b0);
    step();
    check("R7 held level no re-set", event_flag, 1'b0);
    irq_pend[6] = 1; evt_clr = 1; step(); evt_clr = 0;
    check("R8 set wins over clear", event_flag, 1'b1);
    wfe_req = 1; step(); wfe_req = 0;
    check("R8 stale event no sleep", sleeping, 1'b0);
    check("R8 stale event consumed", event_flag, 1'b0);
    irq_pend = '0; step();
    check("R7 falling edge no event", event_flag, 1'b0);
    wfe_req = 1; step(); wfe_req = 0;
    check("R7 wfe sleeps", sleeping, 1'b1);
    irq_pend[7] = 1; settle();
    check("R7 pending event wakes wfe", sleeping, 1'b0);
    step();
    check("R7 wake event consumed", event_flag, 1'b0);
    irq_pend = '0; cfg_sev_on_pend = 0; step();
  endtask

  task automatic t_sleep_on_exit();
    cfg_sleep_on_exit = 1;
    handler_exit = 1; exit_to_thread = 0; step(); handler_exit = 0;
    check("R9 nested exit stays awake", sleeping, 1'b0);
    handler_exit = 1; exit_to_thread = 1; step(); handler_exit = 0;
    check("R9 thread exit sleeps", sleeping, 1'b1);
    handler_exit = 1; step(); handler_exit = 0;
    check("R11 exit while asleep ignored", sleeping, 1'b1);
    irq_pend[4] = 1; irq_en[4] = 1; settle();
    check("R9 wakes on live line", sleeping, 1'b0);
    step(); irq_pend = '0; irq_en = '0; step();
    cfg_sleep_on_exit = 0;
    handler_exit = 1; step(); handler_exit = 0; exit_to_thread = 0;
    check("R9 bit clear stays awake", sleeping, 1'b0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_wfi_sleep_wake();
    t_wfi_blocked();
    t_deep_and_ignore();
    t_wfe_event();
    t_wfe_irq();
    t_wfe_latched();
    t_sev_on_pend();
    t_sleep_on_exit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule